// File: doc/BRIEF.md
# Tournament Branch Predictor

This block guesses the direction of conditional branches. It runs two predictors side by side and lets a third table choose between them. The first predictor is local. A table of per-branch outcome histories, addressed by instruction address bits, picks one of a set of 3-bit saturating counters. The second predictor is global. A shift register holds the outcomes of the most recent branches and picks one of a set of 2-bit saturating counters. The chooser is a table of 2-bit counters addressed by instruction address bits. Each chooser counter learns which of the two predictors has been more reliable for the branches that map to it.

The fetch side presents an address on the predict port and reads back a direction in the same cycle. A flag on that port shows which component supplied the answer. When a branch resolves, the execute side presents the branch address and its real outcome on the update port. On that clock edge the block trains all three counters, using the indices that the current state gives for that address. It then shifts the outcome into that branch's local history and into the global history. No history is advanced speculatively, so the predict port sees new state only after an update edge. The tables have no address tags. Branches whose index bits match therefore share entries.

Top module: `tp_tournament`

## Requirements
- R1: After reset every address predicts not taken and the chooser selects the global component (`pred_use_global`=1). Reset values: chooser counters 2, local counters 3, global counters 1, all histories 0.
- R2: `pred_taken` equals the global prediction when the chooser counter at index `pc[13:2]` is 2 or more, and equals the local prediction otherwise. `pred_use_global` is 1 exactly when that counter is 2 or more.
- R3: The local prediction reads the 10-bit history at index `pc[11:2]`. That history value addresses a 3-bit counter, and the local prediction is taken when the counter is 4 or more.
- R4: The global prediction reads the 2-bit counter addressed by the 12-bit global history, and is taken when the counter is 2 or more.
- R5: On an accepted update, the local and global counters that supplied the predictions for `upd_pc` count up on taken and down on not taken. They saturate at 0 and at 7 (local) or 3 (global).
- R6: On an accepted update, the chooser counter for `upd_pc` does not change when both components were right or both were wrong. It counts down (toward local) when only the local component was right, and up (toward global) when only the global component was right. It saturates at 0 and 3.
- R7: After the counters are trained with the pre-update indices, the outcome (1 = taken) is shifted into bit 0 of the local history entry and into bit 0 of the global history. Bit i then holds the outcome of the i-th most recent branch, older bits moving one place up.
- R8: While `upd_valid` is 0, `upd_pc` and `upd_taken` have no effect on any state.
- R9: There are no address tags. Addresses that agree in bits 13:2 share their chooser counter and their local history entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| pred_use_global | output | 1 | 1 when the global component supplied `pred_taken` |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench keeps an independent table model and checks every prediction against it. It runs a loop-style pattern (seven taken, one not taken), in which the local history learns the exit and the chooser should drift toward local. A design that moved the chooser when both components agreed on correctness, or moved it the wrong way, would show the wrong source flag in that pattern. Long taken runs followed by reversals expose counters that wrap instead of saturating, and a design that shifted history before training would index the wrong counters on the very first update. Address pairs that differ only above bit 13 must interfere with each other, and strobe-free cycles with changing update inputs must leave all predictions unchanged.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Saturating step of a counter that spans 0..top.
  function automatic int sat_step(int v, logic up, int top);
    if (up) return (v < top) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  // Chooser step: low values favour local, high values favour global.
  function automatic int pick_step(int v, logic local_ok, logic global_ok, int top);
    if (local_ok && !global_ok) return (v > 0) ? v - 1 : v;
    if (global_ok && !local_ok) return (v < top) ? v + 1 : v;
    return v;
  endfunction

  // A counter of width w votes taken when its top bit is set.
  function automatic logic ctr_votes_taken(int v, int w);
    return v >= (1 << (w - 1));
  endfunction

endpackage

// File: rtl/tp_local.sv
module tp_local
  import tp_pkg::*;
#(
  parameter int SLOT_BITS = 10,
  parameter int HIST_W    = 10,
  parameter int CTR_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_BITS-1:0] p_slot,
  output logic                 p_taken,
  input  logic                 upd_valid,
  input  logic [SLOT_BITS-1:0] u_slot,
  input  logic                 upd_taken,
  output logic                 u_taken_guess
);
  localparam int SLOTS    = 1 << SLOT_BITS;
  localparam int CTRS     = 1 << HIST_W;
  localparam int CTR_MAX  = (1 << CTR_W) - 1;
  localparam int CTR_RST  = (1 << (CTR_W - 1)) - 1;

  logic [HIST_W-1:0] hist_tab [SLOTS];
  logic [CTR_W-1:0]  ctr_tab  [CTRS];

  logic [HIST_W-1:0] p_hist, u_hist, u_hist_next;
  logic [CTR_W-1:0]  p_ctr, u_ctr, u_ctr_next;

  assign p_hist  = hist_tab[p_slot];
  assign p_ctr   = ctr_tab[p_hist];
  assign p_taken = ctr_votes_taken(int'(p_ctr), CTR_W);

  assign u_hist        = hist_tab[u_slot];
  assign u_ctr         = ctr_tab[u_hist];
  assign u_taken_guess = ctr_votes_taken(int'(u_ctr), CTR_W);
  assign u_ctr_next    = CTR_W'(sat_step(int'(u_ctr), upd_taken, CTR_MAX));
  assign u_hist_next   = {u_hist[HIST_W-2:0], upd_taken};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) hist_tab[i] <= '0;
      for (int j = 0; j < CTRS; j++)  ctr_tab[j]  <= CTR_W'(CTR_RST);
    end else if (upd_valid) begin
      ctr_tab[u_hist]  <= u_ctr_next;
      hist_tab[u_slot] <= u_hist_next;
    end
  end

  assert_local_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && u_ctr == CTR_W'(CTR_MAX))
      |=> ctr_tab[$past(u_hist)] == CTR_W'(CTR_MAX));

  assert_local_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_tab[$past(u_slot)][0] == $past(upd_taken));

endmodule

// File: rtl/tp_global.sv
module tp_global
  import tp_pkg::*;
#(
  parameter int GH_W  = 12,
  parameter int CTR_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic g_taken,
  input  logic upd_valid,
  input  logic upd_taken
);
  localparam int CTRS    = 1 << GH_W;
  localparam int CTR_MAX = (1 << CTR_W) - 1;
  localparam int CTR_RST = (1 << (CTR_W - 1)) - 1;

  logic [GH_W-1:0]  ghist;
  logic [CTR_W-1:0] ctr_tab [CTRS];
  logic [CTR_W-1:0] g_ctr, g_ctr_next;

  assign g_ctr      = ctr_tab[ghist];
  assign g_taken    = ctr_votes_taken(int'(g_ctr), CTR_W);
  assign g_ctr_next = CTR_W'(sat_step(int'(g_ctr), upd_taken, CTR_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < CTRS; i++) ctr_tab[i] <= CTR_W'(CTR_RST);
    end else if (upd_valid) begin
      ctr_tab[ghist] <= g_ctr_next;
      ghist          <= {ghist[GH_W-2:0], upd_taken};
    end
  end

  assert_global_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && g_ctr == '0) |=> ctr_tab[$past(ghist)] == '0);

  assert_global_age_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist[0] == $past(upd_taken)) && (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));

  assert_global_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser
  import tp_pkg::*;
#(
  parameter int SEL_BITS = 12,
  parameter int CTR_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_BITS-1:0] p_sel,
  output logic                p_use_global,
  input  logic                upd_valid,
  input  logic [SEL_BITS-1:0] u_sel,
  input  logic                local_ok,
  input  logic                global_ok
);
  localparam int ENTRIES = 1 << SEL_BITS;
  localparam int CTR_MAX = (1 << CTR_W) - 1;
  localparam int CTR_RST = 1 << (CTR_W - 1);

  logic [CTR_W-1:0] pick_tab [ENTRIES];
  logic [CTR_W-1:0] p_pick, u_pick, u_pick_next;
  logic             pick_moves;

  assign p_pick       = pick_tab[p_sel];
  assign p_use_global = ctr_votes_taken(int'(p_pick), CTR_W);
  assign u_pick       = pick_tab[u_sel];
  assign u_pick_next  = CTR_W'(pick_step(int'(u_pick), local_ok, global_ok, CTR_MAX));
  assign pick_moves   = local_ok ^ global_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pick_tab[i] <= CTR_W'(CTR_RST);
    end else if (upd_valid) begin
      pick_tab[u_sel] <= u_pick_next;
    end
  end

  assert_pick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !pick_moves) |=> pick_tab[$past(u_sel)] == $past(u_pick));

  assert_pick_to_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && local_ok && !global_ok && u_pick != '0)
      |=> pick_tab[$past(u_sel)] == $past(u_pick) - CTR_W'(1));

  assert_pick_to_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && global_ok && !local_ok && u_pick != CTR_W'(CTR_MAX))
      |=> pick_tab[$past(u_sel)] == $past(u_pick) + CTR_W'(1));

endmodule

// File: rtl/tp_tournament.sv
module tp_tournament #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int SLOT_BITS = 10,
  parameter int HIST_W    = 10,
  parameter int LCTR_W    = 3,
  parameter int GH_W      = 12,
  parameter int GCTR_W    = 2,
  parameter int SEL_BITS  = 12,
  parameter int PICK_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_use_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_TOP = PC_LSB + SEL_BITS;

  logic [SLOT_BITS-1:0] p_slot, u_slot;
  logic [SEL_BITS-1:0]  p_sel, u_sel;
  logic                 l_pred, l_upd_guess, g_pred;
  logic                 local_ok, global_ok;
  logic                 unused_pc_bits;

  assign p_sel  = pred_pc[PC_LSB +: SEL_BITS];
  assign u_sel  = upd_pc[PC_LSB +: SEL_BITS];
  assign p_slot = pred_pc[PC_LSB +: SLOT_BITS];
  assign u_slot = upd_pc[PC_LSB +: SLOT_BITS];
  assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_TOP], pred_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:IDX_TOP], upd_pc[PC_LSB-1:0]};

  tp_local #(.SLOT_BITS(SLOT_BITS), .HIST_W(HIST_W), .CTR_W(LCTR_W)) u_local (
    .clk(clk), .rst_n(rst_n), .p_slot(p_slot), .p_taken(l_pred),
    .upd_valid(upd_valid), .u_slot(u_slot), .upd_taken(upd_taken),
    .u_taken_guess(l_upd_guess)
  );

  tp_global #(.GH_W(GH_W), .CTR_W(GCTR_W)) u_global (
    .clk(clk), .rst_n(rst_n), .g_taken(g_pred),
    .upd_valid(upd_valid), .upd_taken(upd_taken)
  );

  assign local_ok  = (l_upd_guess == upd_taken);
  assign global_ok = (g_pred == upd_taken);

  tp_chooser #(.SEL_BITS(SEL_BITS), .CTR_W(PICK_W)) u_chooser (
    .clk(clk), .rst_n(rst_n), .p_sel(p_sel), .p_use_global(pred_use_global),
    .upd_valid(upd_valid), .u_sel(u_sel), .local_ok(local_ok), .global_ok(global_ok)
  );

  assign pred_taken = pred_use_global ? g_pred : l_pred;

  assert_pick_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_pred == g_pred) |-> (pred_taken == l_pred));

endmodule

// File: tb/sim_tp_tournament.sv
module sim_tp_tournament;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_use_global;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_tournament u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_use_global(pred_use_global), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // Independent table model
  int m_hist [1024];
  int m_lc   [1024];
  int m_gc   [4096];
  int m_pick [4096];
  int m_gh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic  q_taken [$];
  logic  q_useg  [$];
  string q_tag_t [$];
  string q_tag_g [$];

  function automatic bit m_local(logic [31:0] pc);
    return m_lc[m_hist[pc[11:2]]] > 3;
  endfunction
  function automatic bit m_global();
    return m_gc[m_gh] > 1;
  endfunction
  function automatic bit m_useg(logic [31:0] pc);
    return m_pick[pc[13:2]] > 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) begin m_hist[i] = 0; m_lc[i] = 3; end
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_pick[i] = 2; end
    m_gh = 0;
  endtask

  task automatic model_update(logic [31:0] pc, bit t);
    int slot, h, sel;
    bit lp, gp;
    slot = int'(pc[11:2]);
    sel  = int'(pc[13:2]);
    h  = m_hist[slot];
    lp = m_local(pc);
    gp = m_global();
    if (lp == t && gp != t && m_pick[sel] > 0) m_pick[sel]--;
    if (gp == t && lp != t && m_pick[sel] < 3) m_pick[sel]++;
    if (t) begin
      if (m_lc[h] < 7) m_lc[h]++;
      if (m_gc[m_gh] < 3) m_gc[m_gh]++;
    end else begin
      if (m_lc[h] > 0) m_lc[h]--;
      if (m_gc[m_gh] > 0) m_gc[m_gh]--;
    end
    m_hist[slot] = ((h << 1) | int'(t)) & 1023;
    m_gh = ((m_gh << 1) | int'(t)) & 4095;
  endtask

  // Driver: predict with model-computed expectation
  task automatic predict(logic [31:0] pc, string tag_t, string tag_g);
    bit ug;
    @(posedge clk); #1;
    pred_pc = pc;
    ug = m_useg(pc);
    q_taken.push_back(ug ? m_global() : m_local(pc));
    q_useg.push_back(ug);
    q_tag_t.push_back(tag_t);
    q_tag_g.push_back(tag_g);
  endtask

  // Driver: predict with a hand-derived expectation
  task automatic predict_fixed(logic [31:0] pc, logic et, logic eg, string tag);
    @(posedge clk); #1;
    pred_pc = pc;
    q_taken.push_back(et);
    q_useg.push_back(eg);
    q_tag_t.push_back(tag);
    q_tag_g.push_back(tag);
  endtask

  task automatic update(logic [31:0] pc, bit t);
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    model_update(pc, t);
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic step(logic [31:0] pc, bit t, string tag_t, string tag_g);
    predict(pc, tag_t, tag_g);
    update(pc, t);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (q_taken.size() > 0) begin
      logic et, eg;
      string tt, tg;
      et = q_taken.pop_front(); eg = q_useg.pop_front();
      tt = q_tag_t.pop_front(); tg = q_tag_g.pop_front();
      checks++;
      if (pred_taken !== et) begin
        errors++;
        $display("FAIL %s pred_taken pc=%h actual=%b expected=%b", tt, pred_pc, pred_taken, et);
      end
      checks++;
      if (pred_use_global !== eg) begin
        errors++;
        $display("FAIL %s pred_use_global pc=%h actual=%b expected=%b", tg, pred_pc, pred_use_global, eg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] pcs [8];
    bit last_t;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, hand values
    predict_fixed(32'h0000_0100, 1'b0, 1'b1, "R1");
    predict_fixed(32'h0000_3ffc, 1'b0, 1'b1, "R1");
    predict_fixed(32'h8000_0000, 1'b0, 1'b1, "R1");

    // R7: one taken update; counters at index 0 trained, histories moved off index 0
    update(32'h0000_0100, 1'b1);
    predict_fixed(32'h0000_0100, 1'b0, 1'b1, "R7");
    predict(32'h0000_0100, "R7", "R6");

    // R3 / R6: loop pattern, seven taken then one exit
    for (int it = 0; it < 16; it++)
      for (int k = 0; k < 8; k++)
        step(32'h0000_0240, (k != 7), "R3", "R6");

    // R5: long taken run then reversals on another branch
    for (int k = 0; k < 30; k++) step(32'h0000_0a00, 1'b1, "R5", "R2");
    predict_fixed(32'h0000_0a00, 1'b1, m_useg(32'h0000_0a00), "R5");
    for (int k = 0; k < 6; k++) step(32'h0000_0a00, 1'b0, "R5", "R2");
    for (int k = 0; k < 20; k++) step(32'h0000_0a00, 1'b0, "R5", "R2");

    // R8: strobe-free noise on the update inputs
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      upd_pc = 32'h0000_0240 ^ (k << 2); upd_taken = k[0];
    end
    predict(32'h0000_0240, "R8", "R8");
    predict(32'h0000_0a00, "R8", "R8");
    predict(32'h0000_0244, "R8", "R8");

    // R9: two addresses sharing bits 13:2
    for (int k = 0; k < 24; k++) begin
      step(32'h0000_1040, k[1], "R9", "R9");
      step(32'h0004_1040, !k[0], "R9", "R9");
    end

    // R4 / R2: mixed, partly correlated traffic
    pcs[0] = 32'h0000_0040; pcs[1] = 32'h0000_0044; pcs[2] = 32'h0000_0048;
    pcs[3] = 32'h0000_0200; pcs[4] = 32'h0000_0204; pcs[5] = 32'h0000_1000;
    pcs[6] = 32'h0000_3008; pcs[7] = 32'h0000_4040;
    lfsr = 16'hace1;
    last_t = 1'b0;
    for (int k = 0; k < 400; k++) begin
      int sel;
      bit t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = int'(lfsr[2:0]);
      if (sel < 4) t = last_t ^ (sel == 1);
      else t = lfsr[7];
      step(pcs[sel], t, "R4", "R2");
      last_t = t;
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule